// File: doc/BRIEF.md
# Six-Slot Lap-Flag Synchronous FIFO

This block is a single-clock first-in first-out queue whose storage depth does not have to be a power of two. The default depth is six. Each of the two pointers holds a slot number and, above it, a single lap bit. The slot number counts from zero up to the last slot and then goes back to zero, and at that wrap the lap bit toggles. No mask and no modulus is applied anywhere. With the default depth the raw pointer value therefore runs through 0..5, then 8..13, then returns to 0. Codes 6, 7, 14 and 15 never occur.

One producer and one consumer share the clock. The producer offers a word with `push_valid` and must respect `is_full`. The consumer requests a word with `pop_ready` and must respect `is_empty`. If both sides are accepted in the same cycle, both proceed. The popped word is registered and appears on `pop_data` one cycle after the read is accepted. `fill_level` reports how many entries are held.

Top module: `lap_fifo`

## Requirements
- R1: After reset, `is_empty` is 1, `is_full` is 0 and `fill_level` is 0.
- R2: Words leave in the order they were accepted. The word for an accepted read is on `pop_data` after the next rising clock edge and holds until the next accepted read.
- R3: A write offered while `is_full` is 1 is dropped. It does not change the stored contents, the write pointer or `fill_level`.
- R4: A read requested while `is_empty` is 1 is dropped. `pop_data` and `fill_level` are unchanged.
- R5: `is_full` is 1 exactly when DEPTH entries are held. `is_empty` is 1 exactly when none are held.
- R6: `fill_level` equals the number of held entries and never exceeds DEPTH.
- R7: When the queue is neither empty nor full, a read and a write in the same cycle are both accepted, and `fill_level` is unchanged.
- R8: A pointer at slot DEPTH-1 advances to slot 0 and toggles its lap bit. A slot value of DEPTH or more never occurs. Ordering holds across any number of laps.
- R9: When full, a simultaneous read and write pops one word, drops the write, and leaves `fill_level` at DEPTH-1. When empty, a simultaneous read and write stores the word, drops the read, leaves `fill_level` at 1, and leaves `pop_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_data | input | DATA_W | Word offered for writing |
| push_valid | input | 1 | Write request |
| is_full | output | 1 | Queue holds DEPTH entries |
| pop_ready | input | 1 | Read request |
| pop_data | output | DATA_W | Registered word from the last accepted read |
| is_empty | output | 1 | Queue holds no entries |
| fill_level | output | $clog2(DEPTH+1) | Number of held entries |

## Verification
Directed sequences first fill the queue, then push against full, then drain it, then pop against empty. These separate dropped requests from accepted ones at both boundaries. Simultaneous read and write is applied at empty, at full and in between, which shows whether acceptance is decided per side. A long seeded random mix of pushes and pops drives both pointers through many laps, so a wrong skip in the slot sequence or a wrong lap comparison shows up as reordered data or a wrong level.

// File: rtl/lap_fifo_pkg.sv
package lap_fifo_pkg;
    localparam int unsigned DEF_DEPTH  = 6;
    localparam int unsigned DEF_DATA_W = 8;

    // Entries held, derived from the two lap/slot pairs
    function automatic int unsigned occupancy(
        input logic        w_lap,
        input int unsigned w_slot,
        input logic        r_lap,
        input int unsigned r_slot,
        input int unsigned depth
    );
        if (w_lap == r_lap) return w_slot - r_slot;
        else                return depth - r_slot + w_slot;
    endfunction
endpackage

// File: rtl/lap_fifo_ptr.sv
module lap_fifo_ptr #(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic              lap,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(DEPTH - 1);

    typedef struct packed {
        logic              lap;
        logic [SLOT_W-1:0] slot;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.slot == LAST) begin
                st_d.slot = '0;
                st_d.lap  = ~st_q.lap;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lap  = st_q.lap;
    assign slot = st_q.slot;

    assert_slot_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

    assert_wrap_flips_lap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && slot == LAST) |=> (slot == '0 && lap != $past(lap)));
endmodule

// File: rtl/lap_fifo_mem.sv
module lap_fifo_mem #(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [SLOT_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] cells;
        logic [DATA_W-1:0]            rdata;
    } mem_t;

    mem_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we && waddr == SLOT_W'(i)) st_d.cells[i] = wdata;
            if (re && raddr == SLOT_W'(i)) st_d.rdata    = st_q.cells[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    assert_rdata_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/lap_fifo.sv
module lap_fifo #(
    parameter int unsigned DEPTH  = lap_fifo_pkg::DEF_DEPTH,
    parameter int unsigned DATA_W = lap_fifo_pkg::DEF_DATA_W,
    localparam int unsigned SLOT_W = (DEPTH > 2) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_valid,
    output logic              is_full,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data,
    output logic              is_empty,
    output logic [CNT_W-1:0]  fill_level
);
    logic              w_lap, r_lap;
    logic [SLOT_W-1:0] w_slot, r_slot;
    logic              wr_ok, rd_ok;

    assign is_empty = (w_lap == r_lap) && (w_slot == r_slot);
    assign is_full  = (w_lap != r_lap) && (w_slot == r_slot);
    assign wr_ok    = push_valid && !is_full;
    assign rd_ok    = pop_ready && !is_empty;

    always_comb begin
        fill_level = CNT_W'(lap_fifo_pkg::occupancy(w_lap, int'(w_slot),
                                                    r_lap, int'(r_slot), DEPTH));
    end

    lap_fifo_ptr #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) wr_ptr_i (
        .clk(clk), .rst_n(rst_n), .adv(wr_ok), .lap(w_lap), .slot(w_slot));

    lap_fifo_ptr #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) rd_ptr_i (
        .clk(clk), .rst_n(rst_n), .adv(rd_ok), .lap(r_lap), .slot(r_slot));

    lap_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_ok), .waddr(w_slot), .wdata(push_data),
        .re(rd_ok), .raddr(r_slot), .rdata(pop_data));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && !pop_ready) |=> (is_full && $stable(w_slot) && $stable(w_lap)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && !push_valid) |=> (is_empty && $stable(pop_data)));

    assert_full_matches_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_full == (fill_level == CNT_W'(DEPTH)));

    assert_level_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH));

    assert_both_keep_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_empty && !is_full && push_valid && pop_ready) |=> $stable(fill_level));

    assert_full_both_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_valid && pop_ready) |=> (fill_level == CNT_W'(DEPTH - 1)));
endmodule

// File: tb/lap_fifo_tb_top.sv
module lap_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 6;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 0;
    logic              rst_n = 0;
    logic [DATA_W-1:0] push_data = '0;
    logic              push_valid = 0;
    logic              pop_ready = 0;
    logic              is_full, is_empty;
    logic [DATA_W-1:0] pop_data;
    logic [CNT_W-1:0]  fill_level;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lap_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_data(push_data), .push_valid(push_valid),
        .is_full(is_full), .pop_ready(pop_ready), .pop_data(pop_data),
        .is_empty(is_empty), .fill_level(fill_level));

    function automatic int exp_level();
        return model_q.size();
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive, check flags, clock, check data
    task automatic step(input bit wv, input logic [DATA_W-1:0] wd, input bit rr,
                        input string tag);
        bit will_w, will_r;
        @(negedge clk);
        push_valid = wv; push_data = wd; pop_ready = rr;
        #1;
        check(is_full == (exp_level() == DEPTH), "R5 full", int'(is_full), int'(exp_level() == DEPTH));
        check(is_empty == (exp_level() == 0), "R5 empty", int'(is_empty), int'(exp_level() == 0));
        check(int'(fill_level) == exp_level(), "R6 level", int'(fill_level), exp_level());
        will_w = wv && (exp_level() < DEPTH);
        will_r = rr && (exp_level() > 0);
        @(posedge clk); #1;
        if (will_r) exp_rd = model_q.pop_front();
        if (will_w) model_q.push_back(wd);
        check(pop_data == exp_rd, tag, int'(pop_data), int'(exp_rd));
        check(int'(fill_level) == exp_level(), tag, int'(fill_level), exp_level());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 3);
        #1;
        check(is_empty && !is_full && fill_level == 0, "R1 reset", int'(fill_level), 0);
        @(negedge clk); rst_n = 1;
        #1;
        check(is_empty == 1'b1, "R1 empty after reset", int'(is_empty), 1);

        // Fill to full
        for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, "R2 fill");
        check(is_full == 1'b1, "R5 full at depth", int'(is_full), 1);
        // Push against full
        step(1, 8'hEE, 0, "R3 write while full");
        step(1, 8'hEF, 0, "R3 write while full");
        // Drain: order proves the dropped writes did not overwrite
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 1, "R3 drain order");
        // Pop against empty
        step(0, 8'h00, 1, "R4 read while empty");
        step(0, 8'h00, 1, "R4 read while empty");
        // Both at empty
        step(1, 8'h5A, 1, "R9 both at empty");
        // Middle simultaneous
        step(1, 8'h5B, 0, "R2 push");
        step(1, 8'h5C, 1, "R7 both in middle");
        step(1, 8'h5D, 1, "R7 both in middle");
        // Fill and both at full
        while (model_q.size() < DEPTH) step(1, 8'h60 + 8'(model_q.size()), 0, "R2 refill");
        step(1, 8'hAA, 1, "R9 both at full");
        step(0, 8'h00, 0, "R9 after both at full");
        // Random traffic across many laps
        for (int i = 0; i < 3000; i++) begin
            step(bit'($urandom_range(0, 99) < 55), 8'($urandom), bit'($urandom_range(0, 99) < 50),
                 "R8 lap traffic");
        end
        while (model_q.size() > 0) step(0, 8'h00, 1, "R8 final drain");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule